// File: doc/BRIEF.md
# Automatic Bus-Off Recovery Timer

This block sits beside the protocol engine of a CAN-style controller. Its job is to bring the controller back onto the bus without software help after the controller has gone bus-off. Software loads a 32-bit wait time into a read/write preload register and sets an enable bit in the controller's control register. When the engine reports a bus-off event, the timer copies the preload value into its counter and counts clock cycles down to zero. On reaching zero it drives a one-cycle pulse that clears the controller's initialization bit, and that pulse starts the recovery sequence. The counter is then refilled from the preload register.

The countdown can be held or cancelled. A debug/suspend input freezes the count without losing it. Any write to the control register while the count is running cancels the procedure. Clearing the enable bit also cancels it. A status output shows whether a countdown is in progress.

Top module: `can_autorec_timer`

## Requirements
- R1: After reset the preload register reads 0, `running` is 0 and `init_clr` is 0.
- R2: A cycle with `pre_wr` high stores all 32 bits of `pre_wdata` into the preload register. `pre_rdata` shows the stored value from the next cycle on.
- R3: While idle, a cycle with `bus_off`=1, `auto_en`=1 and `ctrl_wr`=0 arms the timer, and `running` is 1 in the next cycle. With `auto_en`=0, or with `ctrl_wr`=1 in that cycle, `bus_off` does not arm it.
- R4: With preload P and no suspend, `init_clr` is high for exactly one cycle: the cycle that follows the P-th clock edge after the arming edge. With P=0 this is the cycle directly after bus-off was detected.
- R5: `running` is 0 in the cycle after the `init_clr` pulse. A later bus-off then produces the same timing again, because the counter is refilled from the preload.
- R6: A cycle with `ctrl_wr`=1 while running cancels the countdown, and `running` is 0 in the next cycle. No `init_clr` pulse follows. This includes a `ctrl_wr` that falls in the cycle the count reaches zero: that pulse is suppressed.
- R7: Dropping `auto_en` while running cancels the countdown, and `running` is 0 in the next cycle. No pulse follows, even after `auto_en` returns.
- R8: Each cycle with `suspend`=1 while running holds the count and blocks the pulse. The pulse is delayed by exactly that many cycles.
- R9: A `bus_off` that arrives while running is ignored. The pulse keeps its original timing.
- R10: Writing the preload while running does not change the countdown in progress. The new value applies from the next arming on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Module clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pre_wr | input | 1 | Preload register write strobe |
| pre_wdata | input | 32 | Preload write data |
| pre_rdata | output | 32 | Preload register read data |
| auto_en | input | 1 | Automatic recovery enable bit from the control register |
| ctrl_wr | input | 1 | Strobe: a write to the control register occurred |
| bus_off | input | 1 | Bus-off event from the protocol engine |
| suspend | input | 1 | Debug/suspend: freeze a running countdown |
| init_clr | output | 1 | One-cycle pulse that clears the init bit |
| running | output | 1 | Countdown in progress |

## Verification
Two pairs of events can collide in one cycle. The first is the zero-count cycle that would raise `init_clr`, landing together with a control-register write. The second is that same zero-count cycle landing together with an asserted suspend. The bench counts edges from the arming edge and drives `ctrl_wr` or `suspend` in exactly the cycle where the count hits zero. It judges the first case by the absence of any pulse afterwards and by `running` dropping. It judges the second by the pulse moving later by exactly the number of suspended cycles.

// File: rtl/can_autorec_timer.sv
module can_autorec_timer #(
  parameter int CW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          pre_wr,
  input  logic [CW-1:0] pre_wdata,
  output logic [CW-1:0] pre_rdata,
  input  logic          auto_en,
  input  logic          ctrl_wr,
  input  logic          bus_off,
  input  logic          suspend,
  output logic          init_clr,
  output logic          running
);

  logic [CW-1:0] preload_q, cnt_q;
  logic          run_q;

  wire go  = run_q && auto_en && !ctrl_wr;
  wire arm = !run_q && bus_off && auto_en && !ctrl_wr;

  assign init_clr  = go && !suspend && (cnt_q == '0);
  assign running   = run_q;
  assign pre_rdata = preload_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      preload_q <= '0;
    else if (pre_wr) preload_q <= pre_wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q <= 1'b0;
      cnt_q <= '0;
    end else if (arm) begin
      run_q <= 1'b1;
      cnt_q <= preload_q;
    end else if ((run_q && !go) || init_clr) begin
      run_q <= 1'b0;
      cnt_q <= preload_q;
    end else if (go && !suspend) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  AST_ARM: assert property (@(posedge clk) disable iff (!rst_n)
    (!running && bus_off && auto_en && !ctrl_wr) |=> running); // R3
  AST_NO_ARM_DISABLED: assert property (@(posedge clk) disable iff (!rst_n)
    (!running && !auto_en) |=> !running); // R3
  AST_COUNT_DOWN: assert property (@(posedge clk) disable iff (!rst_n)
    (run_q && auto_en && !ctrl_wr && !suspend && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - 1'b1)); // R4
  AST_PULSE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    init_clr |=> !init_clr); // R4
  AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    init_clr |=> !running); // R5
  AST_ABORT_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (running && ctrl_wr) |-> !init_clr ##1 !running); // R6
  AST_ABORT_DISABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (running && !auto_en) |=> !running); // R7
  AST_SUSPEND_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (running && suspend && auto_en && !ctrl_wr) |=> (running && $stable(cnt_q))); // R8
  AST_SUSPEND_NO_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    suspend |-> !init_clr); // R8

endmodule

// File: tb/test_can_autorec_timer.sv
module test_can_autorec_timer;
  logic clk = 0, rst_n = 0;
  logic pre_wr = 0, auto_en = 0, ctrl_wr = 0, bus_off = 0, suspend = 0;
  logic [31:0] pre_wdata = '0, pre_rdata;
  logic init_clr, running;
  int n_chk = 0, n_bad = 0;

  always #10 clk = ~clk;

  can_autorec_timer i_can_autorec_timer (
    .clk(clk), .rst_n(rst_n), .pre_wr(pre_wr), .pre_wdata(pre_wdata),
    .pre_rdata(pre_rdata), .auto_en(auto_en), .ctrl_wr(ctrl_wr),
    .bus_off(bus_off), .suspend(suspend), .init_clr(init_clr), .running(running));

  // {preload, suspended cycles}; pulse expected at k = preload + suspended
  localparam int unsigned TAB [7][2] = '{'{0,0}, '{1,0}, '{5,0}, '{3,2}, '{0,3}, '{17,4}, '{2,1}};

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wr_pre(input logic [31:0] v);
    @(negedge clk); pre_wr = 1; pre_wdata = v;
    @(negedge clk); pre_wr = 0;
  endtask

  // drive bus_off across one edge; returns at negedge k=0 (bus_off low)
  task automatic arm_now();
    @(negedge clk); bus_off = 1;
    @(negedge clk); bus_off = 0;
  endtask

  // from k=start, step through cycles up to limit; report first pulse k and count
  task automatic watch(input int start, input int limit, output int at, output int np);
    at = -1; np = 0;
    for (int k = start; k <= limit; k++) begin
      if (k != start) @(negedge clk);
      #1;
      if (init_clr) begin np++; if (at < 0) at = k; end
    end
  endtask

  int at, np;
  logic r_after;

  initial begin
    #200000000;
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual 1 expected 0");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #35; #1;
    chk(pre_rdata == 0, "R1 preload", pre_rdata, 0);
    chk(running == 0, "R1 running", running, 0);
    chk(init_clr == 0, "R1 init_clr", init_clr, 0);
    @(negedge clk); rst_n = 1;

    wr_pre(32'hA5C3_0F1E);
    chk(pre_rdata == 32'hA5C3_0F1E, "R2 readback", pre_rdata, 32'hA5C3_0F1E);
    wr_pre(32'hFFFF_FFFF);
    chk(pre_rdata == 32'hFFFF_FFFF, "R2 all ones", pre_rdata, 32'hFFFF_FFFF);

    wr_pre(3);
    arm_now(); #1;
    chk(running == 0, "R3 no arm when disabled", running, 0);
    auto_en = 1;
    @(negedge clk); bus_off = 1; ctrl_wr = 1;
    @(negedge clk); bus_off = 0; ctrl_wr = 0; #1;
    chk(running == 0, "R3 no arm with ctrl_wr", running, 0);

    // table of preload/suspend vectors
    foreach (TAB[i]) begin
      wr_pre(TAB[i][0]);
      @(negedge clk); bus_off = 1; suspend = (TAB[i][1] > 0);
      @(negedge clk); bus_off = 0;
      at = -1; np = 0;
      for (int k = 0; k <= 40; k++) begin
        if (k != 0) @(negedge clk);
        suspend = (k < int'(TAB[i][1]));
        #1;
        if (k == 0) chk(running == 1, "R3 armed", running, 1);
        if (init_clr) begin np++; if (at < 0) at = k; end
        if (at == k - 1 && at >= 0) chk(running == 0, "R5 idle after pulse", running, 0);
      end
      suspend = 0;
      chk(at == int'(TAB[i][0] + TAB[i][1]), (TAB[i][1] > 0) ? "R8 delayed pulse" : "R4 pulse time",
          at, TAB[i][0] + TAB[i][1]);
      chk(np == 1, "R4 single pulse", np, 1);
    end

    // repeat after completion gives same timing
    wr_pre(4);
    arm_now(); watch(0, 20, at, np);
    arm_now(); watch(0, 20, at, np);
    chk(at == 4 && np == 1, "R5 rerun timing", at, 4);

    // control write aborts mid-count
    wr_pre(5);
    arm_now(); @(negedge clk); @(negedge clk); ctrl_wr = 1;
    @(negedge clk); ctrl_wr = 0; #1; r_after = running;
    watch(3, 20, at, np);
    chk(r_after == 0, "R6 abort running", r_after, 0);
    chk(np == 0, "R6 no pulse after abort", np, 0);

    // control write in the zero cycle suppresses pulse
    wr_pre(3);
    arm_now();
    for (int k = 1; k <= 3; k++) @(negedge clk);
    ctrl_wr = 1; #1;
    chk(init_clr == 0, "R6 zero-cycle write suppresses", init_clr, 0);
    @(negedge clk); ctrl_wr = 0; #1;
    chk(running == 0, "R6 idle after zero-cycle write", running, 0);
    watch(4, 20, at, np);
    chk(np == 0, "R6 no late pulse", np, 0);

    // dropping enable aborts
    wr_pre(4);
    arm_now(); @(negedge clk); auto_en = 0;
    @(negedge clk); #1; r_after = running; auto_en = 1;
    watch(2, 20, at, np);
    chk(r_after == 0, "R7 disable aborts", r_after, 0);
    chk(np == 0, "R7 no pulse", np, 0);

    // bus_off while running ignored
    wr_pre(4);
    arm_now(); bus_off = 1;
    @(negedge clk); @(negedge clk); bus_off = 0;
    watch(2, 20, at, np);
    chk(at == 4 && np == 1, "R9 bus_off ignored while running", at, 4);

    // preload write during run
    wr_pre(6);
    arm_now(); @(negedge clk); pre_wr = 1; pre_wdata = 2;
    @(negedge clk); pre_wr = 0;
    watch(2, 20, at, np);
    chk(at == 6, "R10 current run unchanged", at, 6);
    arm_now(); watch(0, 20, at, np);
    chk(at == 2 && np == 1, "R10 new value next run", at, 2);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule